// File: doc/BRIEF.md
# USB 1.1 Transparent Repeater Controller

This block steers a one-port, full-speed/low-speed USB repeater that sits between a host-side transceiver and a device-side transceiver. Each port presents three receiver signals: the differential data level and the two single-ended line levels. From these the controller works out which side is talking. It enables the output of the opposite transceiver and tells it what to send: the live J/K data, an SE0, or a closing J that lasts one bit.

After power-up the repeater stays invisible to the host. Its upstream pull-up turns on only after a device has shown a steady J long enough. Once the upstream line has settled to J, the repeater idles. The first K on either side opens a path in that direction. A qualified SE0 on the talking side is copied to the listening side. The path closes after a single J bit, or after eight bit times of J when an SE0 was missed. No pull-up indicates the data rate, so the controller works it out from how soon the first K-to-J edge follows the opening K. A long SE0 seen from the device side counts as a disconnect.

All times are whole clock cycles, set by parameters.

Top module: `usb_repeater_ctrl`

## Requirements
- R1: After reset, no port is driven, `up_pullup` is 0 and `lowspeed` is 1. While `up_pullup` is 0, neither `up_oe` nor `dn_oe` is asserted.
- R2: `up_pullup` rises only after the downstream line has held J (`dn_rcv`=1 with `dn_vp` or `dn_vm` high) for PULLUP_CYC consecutive cycles, and any other downstream state restarts that count. After that, the controller ignores the upstream line until it shows J. In the idle state that follows, nothing is driven.
- R3: In idle, an upstream K (`up_rcv`=0 with a single-ended level high) sets `dn_oe` one cycle later, and `dn_dat` then follows `up_rcv`. A downstream K does the same toward the upstream port through `up_oe` and `up_dat`. A J is 1 and a K is 0 on every `*_dat` pin.
- R4: While data is being repeated, a source J lasting 8 bit times (IDLE_J_BITS × the current bit length) closes the path, and the drive is released.
- R5: An SE0 (both single-ended levels low) on the source side is copied as `*_se0`=1 on the other port once it has lasted LS_QUAL cycles (lowspeed=1) or FS_QUAL cycles (lowspeed=0). A shorter SE0 produces no SE0 on the output.
- R6: When the source leaves SE0, the other port is driven with J (`*_dat`=1, `*_se0`=0) for exactly one bit time: LS_BIT cycles at low speed, FS_BIT cycles at full speed. The drive is then released.
- R7: `lowspeed` is 1 in idle. It clears to 0 only if the first K-to-J edge after the opening K comes fewer than SPD_LIMIT cycles after the path opened. Later edges in the same transaction do not change it.
- R8: A downstream SE0 that lasts DISC_CYC cycles while the downstream port is not being driven drops `up_pullup` and all drive.
- R9: A downstream SE0 seen while the downstream port is being driven, such as during a host reset, never counts toward a disconnect.
- R10: A K of any length on the source side is repeated without a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_rcv | input | 1 | Upstream differential receiver (1 = J) |
| up_vp | input | 1 | Upstream D+ single-ended level |
| up_vm | input | 1 | Upstream D- single-ended level |
| dn_rcv | input | 1 | Downstream differential receiver (1 = J) |
| dn_vp | input | 1 | Downstream D+ single-ended level |
| dn_vm | input | 1 | Downstream D- single-ended level |
| up_oe | output | 1 | Upstream transceiver output enable |
| up_se0 | output | 1 | Drive SE0 on the upstream port |
| up_dat | output | 1 | Upstream drive symbol (1 = J, 0 = K) |
| dn_oe | output | 1 | Downstream transceiver output enable |
| dn_se0 | output | 1 | Drive SE0 on the downstream port |
| dn_dat | output | 1 | Downstream drive symbol (1 = J, 0 = K) |
| up_pullup | output | 1 | Upstream pull-up enable |
| lowspeed | output | 1 | Current bit-rate estimate (1 = low speed) |

## Verification
The bench builds the block with FS_BIT=4, LS_BIT=16, FS_QUAL=2, LS_QUAL=6, SPD_LIMIT=26, PULLUP_CYC=50 and DISC_CYC=40. With these values the attach wait, the eight-bit J timeout (128 cycles) and the disconnect window fit into rows of a few dozen cycles. That makes it practical to check the output one cycle before and one cycle after each boundary. The 100-cycle host reset runs more than twice as long as the disconnect window, so a counter that failed to clear while its port was driven would show up as a lost pull-up. A SYNC edge at 4 cycles and one at 40 cycles fall on opposite sides of the 26-cycle speed limit.

// File: rtl/usb_repeater_ctrl.sv
`timescale 1ns/1ps
module usb_repeater_ctrl #(
  parameter int FS_BIT      = 17,
  parameter int LS_BIT      = 133,
  parameter int FS_QUAL     = 3,
  parameter int LS_QUAL     = 42,
  parameter int SPD_LIMIT   = 108,
  parameter int PULLUP_CYC  = 500,
  parameter int DISC_CYC    = 400,
  parameter int IDLE_J_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_rcv,
  input  logic up_vp,
  input  logic up_vm,
  input  logic dn_rcv,
  input  logic dn_vp,
  input  logic dn_vm,
  output logic up_oe,
  output logic up_se0,
  output logic up_dat,
  output logic dn_oe,
  output logic dn_se0,
  output logic dn_dat,
  output logic up_pullup,
  output logic lowspeed
);

  localparam int JRUN_LS = IDLE_J_BITS * LS_BIT;
  localparam int JRUN_FS = IDLE_J_BITS * FS_BIT;
  localparam int TMAX    = (PULLUP_CYC > JRUN_LS) ? PULLUP_CYC : JRUN_LS;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int CMAX    = (DISC_CYC > LS_QUAL) ? DISC_CYC : LS_QUAL;
  localparam int CW      = $clog2(CMAX + 1);
  localparam int SW      = $clog2(SPD_LIMIT + 1);

  localparam logic [TW-1:0] PU_LAST  = TW'(PULLUP_CYC - 1);
  localparam logic [TW-1:0] LSB_LAST = TW'(LS_BIT - 1);
  localparam logic [TW-1:0] FSB_LAST = TW'(FS_BIT - 1);
  localparam logic [TW-1:0] JLS_LAST = TW'(JRUN_LS - 1);
  localparam logic [TW-1:0] JFS_LAST = TW'(JRUN_FS - 1);
  localparam logic [CW-1:0] C_LSQ    = CW'(LS_QUAL);
  localparam logic [CW-1:0] C_FSQ    = CW'(FS_QUAL);
  localparam logic [CW-1:0] C_DISC   = CW'(DISC_CYC);
  localparam logic [CW-1:0] C_MAX    = CW'(CMAX);
  localparam logic [SW-1:0] S_LIM    = SW'(SPD_LIMIT);

  typedef enum logic [2:0] {ST_DISC, ST_ATTACH, ST_IDLE, ST_DOWN, ST_UP} st_t;
  typedef enum logic [1:0] {PH_DATA, PH_SE0, PH_TAIL} ph_t;

  st_t           state;
  ph_t           phase;
  logic [TW-1:0] tmr;
  logic [SW-1:0] spd;
  logic          spd_pend;
  logic [CW-1:0] up_cnt, dn_cnt;

  wire up_lse0 = ~up_vp & ~up_vm;
  wire dn_lse0 = ~dn_vp & ~dn_vm;
  wire up_j    = up_rcv & ~up_lse0;
  wire up_k    = ~up_rcv & ~up_lse0;
  wire dn_j    = dn_rcv & ~dn_lse0;
  wire dn_k    = ~dn_rcv & ~dn_lse0;

  wire [CW-1:0] qual    = lowspeed ? C_LSQ : C_FSQ;
  wire          up_conf = up_cnt >= qual;
  wire          dn_conf = dn_cnt >= qual;
  wire          is_up   = state == ST_UP;
  wire          src_j    = is_up ? dn_j : up_j;
  wire          src_lse0 = is_up ? dn_lse0 : up_lse0;
  wire          src_conf = is_up ? dn_conf : up_conf;
  wire [TW-1:0] bit_last  = lowspeed ? LSB_LAST : FSB_LAST;
  wire [TW-1:0] jrun_last = lowspeed ? JLS_LAST : JFS_LAST;

  assign up_oe     = state == ST_UP;
  assign dn_oe     = state == ST_DOWN;
  assign up_se0    = up_oe && phase == PH_SE0;
  assign dn_se0    = dn_oe && phase == PH_SE0;
  assign up_dat    = (up_oe && phase == PH_DATA) ? dn_rcv : 1'b1;
  assign dn_dat    = (dn_oe && phase == PH_DATA) ? up_rcv : 1'b1;
  assign up_pullup = state != ST_DISC;

  always_ff @(posedge clk) begin
    if (!rst_n || !up_lse0 || up_oe) up_cnt <= '0;
    else if (up_cnt != C_MAX)        up_cnt <= up_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dn_lse0 || dn_oe) dn_cnt <= '0;
    else if (dn_cnt != C_MAX)        dn_cnt <= dn_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_DISC;
      phase    <= PH_DATA;
      tmr      <= '0;
      spd      <= '0;
      spd_pend <= 1'b0;
      lowspeed <= 1'b1;
    end else begin
      case (state)
        ST_DISC:
          if (!dn_j)               tmr <= '0;
          else if (tmr == PU_LAST) begin state <= ST_ATTACH; tmr <= '0; end
          else                     tmr <= tmr + 1'b1;
        ST_ATTACH:
          if (up_j) state <= ST_IDLE;
        ST_IDLE: begin
          lowspeed <= 1'b1;
          tmr      <= '0;
          spd      <= '0;
          spd_pend <= 1'b0;
          phase    <= PH_DATA;
          if (up_conf)      begin state <= ST_DOWN; phase <= PH_SE0; end
          else if (dn_conf) begin state <= ST_UP;   phase <= PH_SE0; end
          else if (up_k)    begin state <= ST_DOWN; spd_pend <= 1'b1; end
          else if (dn_k)    begin state <= ST_UP;   spd_pend <= 1'b1; end
        end
        ST_DOWN, ST_UP:
          case (phase)
            PH_DATA:
              if (src_conf) begin
                phase    <= PH_SE0;
                spd_pend <= 1'b0;
              end else begin
                if (!src_j)                state <= state;
                if (!src_j)                tmr <= '0;
                else if (tmr == jrun_last) begin state <= ST_IDLE; tmr <= '0; end
                else                       tmr <= tmr + 1'b1;
                if (spd_pend) begin
                  if (src_j) begin
                    spd_pend <= 1'b0;
                    if (spd < S_LIM) lowspeed <= 1'b0;
                  end else if (spd == S_LIM) spd_pend <= 1'b0;
                  else                       spd <= spd + 1'b1;
                end
              end
            PH_SE0:
              if (!src_lse0) begin phase <= PH_TAIL; tmr <= '0; end
            default:
              if (tmr == bit_last) begin
                state <= ST_IDLE;
                phase <= PH_DATA;
                tmr   <= '0;
              end else tmr <= tmr + 1'b1;
          endcase
        default: state <= ST_DISC;
      endcase
      if (state != ST_DISC && dn_cnt >= C_DISC) begin
        state    <= ST_DISC;
        phase    <= PH_DATA;
        tmr      <= '0;
        spd_pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/usb_repeater_ctrl_chk.sv
`timescale 1ns/1ps
module usb_repeater_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic up_rcv,
  input logic up_vp,
  input logic up_vm,
  input logic dn_vp,
  input logic dn_vm,
  input logic up_oe,
  input logic dn_oe,
  input logic dn_se0,
  input logic dn_dat,
  input logic up_pullup
);

  AST_NO_DRIVE_DETACHED: assert property (@(posedge clk) disable iff (!rst_n)
    !up_pullup |-> (!up_oe && !dn_oe)); // R1

  AST_ATTACH_NEEDS_DN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_pullup) |-> $past(dn_vp || dn_vm)); // R2

  AST_DOWN_OPENS_ON_K_OR_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_oe) |-> ($past(!up_rcv) || $past(!up_vp && !up_vm))); // R3

  AST_SE0_COPIED_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_se0) |-> $past(!up_vp && !up_vm)); // R5

  AST_TAIL_IS_J: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_oe && $fell(dn_se0)) |-> dn_dat); // R6

  AST_DETACH_ON_DN_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_pullup) |-> $past(!dn_vp && !dn_vm)); // R8

  AST_DRIVEN_NO_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
    dn_oe |=> up_pullup); // R9

endmodule

bind usb_repeater_ctrl usb_repeater_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .up_rcv(up_rcv), .up_vp(up_vp), .up_vm(up_vm),
  .dn_vp(dn_vp), .dn_vm(dn_vm), .up_oe(up_oe), .dn_oe(dn_oe),
  .dn_se0(dn_se0), .dn_dat(dn_dat), .up_pullup(up_pullup)
);

// File: tb/usb_repeater_ctrl_bench.sv
`timescale 1ns/1ps
module usb_repeater_ctrl_bench;

  localparam logic [1:0] J = 2'd0, K = 2'd1, S = 2'd2;
  localparam int NV = 41;
  // {req[28:25], up[24:23], dn[22:21], len[20:9], pu, ls_care, ls, up oe/se0/dat, dn oe/se0/dat}
  localparam logic [28:0] VEC [NV] = '{
    {4'd2,  S, J, 12'd49,  9'b0_1_1_001_001}, // R2 pull-up still off
    {4'd2,  S, J, 12'd1,   9'b1_1_1_001_001}, // R2 pull-up on
    {4'd2,  S, J, 12'd10,  9'b1_1_1_001_001}, // R2 waits for upstream J
    {4'd2,  J, J, 12'd1,   9'b1_1_1_001_001}, // R2 idle, nothing driven
    {4'd3,  K, J, 12'd1,   9'b1_1_1_001_100}, // R3 upstream K repeated
    {4'd7,  K, J, 12'd3,   9'b1_1_1_001_100}, // R7 still low speed
    {4'd7,  J, J, 12'd4,   9'b1_1_0_001_101}, // R7 early edge -> full speed
    {4'd3,  K, J, 12'd4,   9'b1_1_0_001_100}, // R3
    {4'd3,  J, J, 12'd4,   9'b1_1_0_001_101}, // R3
    {4'd5,  S, J, 12'd1,   9'b1_1_0_001_101}, // R5 short SE0 not copied
    {4'd5,  K, J, 12'd8,   9'b1_1_0_001_100}, // R5
    {4'd5,  S, J, 12'd2,   9'b1_1_0_001_101}, // R5 not yet qualified
    {4'd5,  S, J, 12'd6,   9'b1_1_0_001_111}, // R5 EOP copied
    {4'd6,  J, J, 12'd3,   9'b1_1_0_001_101}, // R6 J tail
    {4'd6,  J, J, 12'd1,   9'b1_1_0_001_101}, // R6 last tail cycle
    {4'd6,  J, J, 12'd1,   9'b1_0_0_001_001}, // R6 released
    {4'd7,  J, J, 12'd1,   9'b1_1_1_001_001}, // R7 idle sets low speed
    {4'd5,  S, J, 12'd5,   9'b1_1_1_001_001}, // R5 short SE0 in idle
    {4'd5,  J, J, 12'd2,   9'b1_1_1_001_001}, // R5
    {4'd5,  S, J, 12'd6,   9'b1_1_1_001_001}, // R5 keep-alive not yet
    {4'd5,  S, J, 12'd1,   9'b1_1_1_001_111}, // R5 keep-alive copied
    {4'd5,  S, J, 12'd25,  9'b1_1_1_001_111}, // R5
    {4'd6,  J, J, 12'd16,  9'b1_1_1_001_101}, // R6 low-speed tail
    {4'd6,  J, J, 12'd1,   9'b1_1_1_001_001}, // R6 released
    {4'd9,  S, S, 12'd7,   9'b1_1_1_001_111}, // R9 host reset relayed
    {4'd9,  S, S, 12'd100, 9'b1_1_1_001_111}, // R9 no disconnect
    {4'd6,  J, J, 12'd16,  9'b1_1_1_001_101}, // R6
    {4'd6,  J, J, 12'd1,   9'b1_1_1_001_001}, // R6
    {4'd10, K, J, 12'd300, 9'b1_1_1_001_100}, // R10 long K relayed
    {4'd5,  S, J, 12'd6,   9'b1_1_1_001_101}, // R5
    {4'd5,  S, J, 12'd26,  9'b1_1_1_001_111}, // R5
    {4'd6,  J, J, 12'd16,  9'b1_1_1_001_101}, // R6
    {4'd6,  J, J, 12'd1,   9'b1_1_1_001_001}, // R6
    {4'd3,  J, K, 12'd1,   9'b1_1_1_100_001}, // R3 downstream K repeated
    {4'd7,  J, K, 12'd39,  9'b1_1_1_100_001}, // R7 late edge keeps low speed
    {4'd4,  J, J, 12'd127, 9'b1_1_1_101_001}, // R4 J run not yet expired
    {4'd4,  J, J, 12'd1,   9'b1_1_1_001_001}, // R4 J run closes path
    {4'd8,  J, S, 12'd6,   9'b1_1_1_001_001}, // R8
    {4'd8,  J, S, 12'd1,   9'b1_1_1_111_001}, // R8 SE0 sent up
    {4'd8,  J, S, 12'd33,  9'b1_1_1_111_001}, // R8
    {4'd8,  J, S, 12'd1,   9'b0_1_1_001_001}  // R8 disconnected
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_rcv, up_vp, up_vm, dn_rcv, dn_vp, dn_vm;
  logic up_oe, up_se0, up_dat, dn_oe, dn_se0, dn_dat, up_pullup, lowspeed;
  int   checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  usb_repeater_ctrl #(
    .FS_BIT(4), .LS_BIT(16), .FS_QUAL(2), .LS_QUAL(6), .SPD_LIMIT(26),
    .PULLUP_CYC(50), .DISC_CYC(40), .IDLE_J_BITS(8)
  ) u_usb_repeater_ctrl (
    .clk(clk), .rst_n(rst_n),
    .up_rcv(up_rcv), .up_vp(up_vp), .up_vm(up_vm),
    .dn_rcv(dn_rcv), .dn_vp(dn_vp), .dn_vm(dn_vm),
    .up_oe(up_oe), .up_se0(up_se0), .up_dat(up_dat),
    .dn_oe(dn_oe), .dn_se0(dn_se0), .dn_dat(dn_dat),
    .up_pullup(up_pullup), .lowspeed(lowspeed)
  );

  function automatic logic [2:0] line(input logic [1:0] s);
    case (s)
      J:       return 3'b110;
      K:       return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

  task automatic drive(input logic [1:0] u, input logic [1:0] d);
    {up_rcv, up_vp, up_vm} = line(u);
    {dn_rcv, dn_vp, dn_vm} = line(d);
  endtask

  task automatic check(input int req, input logic [7:0] exp, input logic [7:0] mask);
    logic [7:0] got;
    got = {up_pullup, lowspeed, up_oe, up_se0, up_dat, dn_oe, dn_se0, dn_dat};
    checks++;
    if ((got & mask) != (exp & mask)) begin
      errors++;
      $display("FAIL R%0d at %0t: got %b expected %b (mask %b)", req, $time, got, exp, mask);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(S, J);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 8'b0_1_001_001, 8'hff); // R1 state under reset
    rst_n = 1'b1;
    check(1, 8'b0_1_001_001, 8'hff); // R1 state after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24:23], VEC[i][22:21]);
      repeat (int'(VEC[i][20:9])) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][28:25]), {VEC[i][8], VEC[i][6:0]}, {1'b1, VEC[i][7], 6'h3f});
    end

    // R2: a steady downstream SE0 never enables the pull-up
    drive(J, S);
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(2, 8'b0_0_001_001, 8'b1_0_111_111);
    // R2: a one-cycle interruption restarts the attach count
    drive(J, J);
    repeat (30) @(posedge clk);
    @(negedge clk);
    drive(J, S);
    @(posedge clk);
    @(negedge clk);
    drive(J, J);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(2, 8'b0_0_001_001, 8'b1_0_111_111);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(2, 8'b1_0_001_001, 8'b1_0_111_111);
    // R3 then R1: reset taken in the middle of a repeated packet
    @(posedge clk);
    @(negedge clk);
    drive(K, J);
    @(posedge clk);
    @(negedge clk);
    check(3, 8'b1_1_001_100, 8'hff);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(1, 8'b0_1_001_001, 8'hff);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule